// File: doc/BRIEF.md
# Strap-Latched Configuration Register Bank

This block keeps the configuration state of a clock-generator device and serves it to a byte-level management port. Software writes one byte at a time by address and reads either a single byte or a block of bytes that starts at a given address. At power-up two frequency-select pins are inputs. Their levels are sampled while an active-low valid strobe is held low. When the strobe is released, the pins are switched to output mode for good.

The bank contains these bytes: a read-only byte with the captured select levels, a set of output-enable and drive-mode control bytes, a spread and test-mode byte, a fixed identification byte and a writable byte count. The byte count sets how long a block read is. The bank also turns the test-mode bit and the two captured selects into a registered CPU frequency value, given in units of 10 kHz, for the rest of the chip. The six control bytes are presented side by side on one bus. Downstream output-gating logic decodes that bus.

Top module: `cfg_bank`

## Requirements
- R1: After reset, `fs_pin_oe` is 0 and both captured selects are 0. On every clock edge where `strap_vld_n` is low, the captured selects are loaded from `fs_a_pin` and `fs_b_pin`. At the first edge after that where `strap_vld_n` is high, the capture locks and `fs_pin_oe` becomes 1 in the next cycle. From then on `fs_pin_oe` stays 1, and later strobe pulses or pin changes have no effect on the captured values.
- R2: Byte 0 is read-only. Bit 0 is the captured FS_A and bit 1 is the captured FS_B. Bits 7:2 read 0, and writes to byte 0 have no effect.
- R3: Reset values are byte1 0x43, byte2 0x00, byte3 0xBF, byte4 0xC7, byte5 0xD7, byte6 0x03 and byte8 0x08. `ctrl_bytes` always equals {byte6, byte5, byte4, byte3, byte2, byte1}, with byte1 in bits 7:0. In every output-enable bit, 1 means enabled. In byte2, 1 means tristated and 0 means driven.
- R4: Byte 7 is read-only and always reads 0x01. The upper nibble holds the revision and the lower nibble holds the vendor code.
- R5: Only these bits are writable: byte1 mask 0xC3, byte2 0xD8, byte3 0xBF, byte4 0xC7, byte5 0xF7, byte6 0xDF and byte8 0xFF. All other bits keep their value and read 0. Writes to addresses 9 to 15 are ignored, and those addresses read 0.
- R6: A request with `rd_block` = 0 returns exactly one byte. `rd_valid` is high in the cycle after the request edge, carrying the byte at `rd_addr`, and is low in the cycle after that.
- R7: A request with `rd_block` = 1 returns as many consecutive bytes as the byte-count value held at the request edge, one per cycle, starting at `rd_addr`. Any address of 8 or above is followed by address 0. A count of 0 returns no bytes.
- R8: A request raised while `rd_valid` is high is ignored, and the read in progress continues unchanged.
- R9: `cpu_freq` is a registered decode of the code {byte6 bit 6, FS_B, FS_A}. The codes 0 to 7 give 10000, 20000, 13333, 16666, 20000, 40000, 26666 and 33333. The output follows a code change one cycle after the edge that changed the code. After reset it is 10000.
- R10: Byte 6 bit 4 selects the 200 MHz SRC rate, bit 3 selects center spread (0 means down spread), and bit 2 enables spread. All three reset to 0 and appear at `ctrl_bytes[44:42]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_vld_n | input | 1 | Active-low strobe that marks the select pins as valid |
| fs_a_pin | input | 1 | Level of the FS_A select pin while it is an input |
| fs_b_pin | input | 1 | Level of the FS_B select pin while it is an input |
| fs_pin_oe | output | 1 | 1 once the select pins have been turned into outputs |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 4 | Byte write address |
| wr_data | input | 8 | Byte write data |
| rd_req | input | 1 | Read request pulse |
| rd_block | input | 1 | 1 selects a block read, 0 a single-byte read |
| rd_addr | input | 4 | Start address of the read |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| ctrl_bytes | output | 48 | Control bytes 6 to 1 side by side |
| cpu_freq | output | 16 | Decoded CPU frequency in units of 10 kHz |

## Verification
A broken capture state shows at the ports the first time byte 0 is read after the strobe is released, or earlier as a `fs_pin_oe` rise at the wrong edge. A wrong write mask or reset value appears at once on `ctrl_bytes` and in the next read of that byte. A broken read pointer or length counter shows up as a wrong byte order or a wrong byte count in the cycles after a request. A stale frequency register is visible one cycle after the test-mode bit is written.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int NBYTES   = 9;
    localparam int AW       = 4;
    localparam int DW       = 8;
    localparam int FW       = 16;
    localparam int IDX_CNT  = 8;
    localparam int TEST_BIT = 6;

    typedef enum logic [1:0] {
        SL_IDLE   = 2'd0,
        SL_SAMPLE = 2'd1,
        SL_DONE   = 2'd2
    } strap_state_e;

    typedef struct packed {
        logic fs_b;
        logic fs_a;
    } strap_t;

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] ptr;
        logic [DW-1:0] left;
    } rdseq_t;

    function automatic logic [DW-1:0] wr_mask(input int idx);
        case (idx)
            1:       return 8'hC3;
            2:       return 8'hD8;
            3:       return 8'hBF;
            4:       return 8'hC7;
            5:       return 8'hF7;
            6:       return 8'hDF;
            8:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DW-1:0] rst_val(input int idx);
        case (idx)
            1:       return 8'h43;
            3:       return 8'hBF;
            4:       return 8'hC7;
            5:       return 8'hD7;
            6:       return 8'h03;
            7:       return 8'h01;
            8:       return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [FW-1:0] freq_of(input logic [2:0] code);
        case (code)
            3'd0:    return 16'd10000;
            3'd1:    return 16'd20000;
            3'd2:    return 16'd13333;
            3'd3:    return 16'd16666;
            3'd4:    return 16'd20000;
            3'd5:    return 16'd40000;
            3'd6:    return 16'd26666;
            default: return 16'd33333;
        endcase
    endfunction

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        if (p >= AW'(IDX_CNT)) return '0;
        return p + 1'b1;
    endfunction

endpackage

// File: rtl/cfg_strap_latch.sv
module cfg_strap_latch
    import cfgbank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   vld_n,
    input  logic   fs_a_pin,
    input  logic   fs_b_pin,
    output strap_t straps,
    output logic   pin_oe
);

    strap_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SL_IDLE;
            straps <= '0;
        end else begin
            case (state)
                SL_IDLE: begin
                    if (!vld_n) begin
                        state  <= SL_SAMPLE;
                        straps <= '{fs_b: fs_b_pin, fs_a: fs_a_pin};
                    end
                end
                SL_SAMPLE: begin
                    if (!vld_n) begin
                        straps <= '{fs_b: fs_b_pin, fs_a: fs_a_pin};
                    end else begin
                        state <= SL_DONE;
                    end
                end
                default: state <= SL_DONE;
            endcase
        end
    end

    assign pin_oe = (state == SL_DONE);

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfgbank_pkg::*;
#(
    parameter logic [7:0] BCNT_RST = 8'd8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  strap_t           straps,
    input  logic [AW-1:0]    rd_sel,
    output logic [DW-1:0]    rd_byte,
    output logic [DW-1:0]    bcount,
    output logic             test_mode,
    output logic [6*DW-1:0]  ctrl_flat
);

    logic [DW-1:0] regs [NBYTES];

    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
        localparam logic [DW-1:0] MASK = wr_mask(gi);
        localparam logic [DW-1:0] RVAL = (gi == IDX_CNT) ? BCNT_RST : rst_val(gi);
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[gi] <= RVAL;
            end else if (wr_en && (wr_addr == AW'(gi))) begin
                regs[gi] <= (wr_data & MASK) | (regs[gi] & ~MASK);
            end
        end
    end

    for (genvar gc = 1; gc <= 6; gc++) begin : g_ctrl
        assign ctrl_flat[(gc-1)*DW +: DW] = regs[gc];
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (rd_sel == AW'(i)) rd_byte = regs[i];
        end
        if (rd_sel == '0) rd_byte = rd_byte | {{(DW-2){1'b0}}, straps};
    end

    assign bcount    = regs[IDX_CNT];
    assign test_mode = regs[6][TEST_BIT];

endmodule

// File: rtl/cfg_read_seq.sv
module cfg_read_seq
    import cfgbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_req,
    input  logic          rd_block,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] bcount,
    output logic          rd_valid,
    output logic [AW-1:0] ptr
);

    rdseq_t        st;
    logic [DW-1:0] req_len;

    assign req_len = rd_block ? bcount : DW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (st.busy) begin
            st.busy <= (st.left != DW'(1));
            st.left <= st.left - 1'b1;
            st.ptr  <= next_ptr(st.ptr);
        end else if (rd_req && (req_len != '0)) begin
            st.busy <= 1'b1;
            st.ptr  <= rd_addr;
            st.left <= req_len;
        end
    end

    assign rd_valid = st.busy;
    assign ptr      = st.ptr;

endmodule

// File: rtl/cfg_freq_dec.sv
module cfg_freq_dec
    import cfgbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    code,
    output logic [FW-1:0] freq
);

    always_ff @(posedge clk) begin
        if (rst) freq <= freq_of(3'd0);
        else     freq <= freq_of(code);
    end

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import cfgbank_pkg::*;
#(
    parameter logic [7:0] BCNT_RST = 8'd8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strap_vld_n,
    input  logic        fs_a_pin,
    input  logic        fs_b_pin,
    output logic        fs_pin_oe,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        rd_req,
    input  logic        rd_block,
    input  logic [3:0]  rd_addr,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic [47:0] ctrl_bytes,
    output logic [15:0] cpu_freq
);

    strap_t        straps;
    logic [AW-1:0] rd_ptr;
    logic [DW-1:0] bcount;
    logic          test_mode;
    logic [2:0]    freq_code;

    cfg_strap_latch u_strap (
        .clk      (clk),
        .rst      (rst),
        .vld_n    (strap_vld_n),
        .fs_a_pin (fs_a_pin),
        .fs_b_pin (fs_b_pin),
        .straps   (straps),
        .pin_oe   (fs_pin_oe)
    );

    cfg_regfile #(.BCNT_RST(BCNT_RST)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .straps    (straps),
        .rd_sel    (rd_ptr),
        .rd_byte   (rd_data),
        .bcount    (bcount),
        .test_mode (test_mode),
        .ctrl_flat (ctrl_bytes)
    );

    cfg_read_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .rd_block (rd_block),
        .rd_addr  (rd_addr),
        .bcount   (bcount),
        .rd_valid (rd_valid),
        .ptr      (rd_ptr)
    );

    assign freq_code = {test_mode, straps.fs_b, straps.fs_a};

    cfg_freq_dec u_freq (
        .clk  (clk),
        .rst  (rst),
        .code (freq_code),
        .freq (cpu_freq)
    );

endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic        strap_vld_n,
    input logic        fs_pin_oe,
    input logic        rd_req,
    input logic        rd_block,
    input logic [3:0]  rd_addr,
    input logic        rd_valid,
    input logic [7:0]  rd_data,
    input logic [3:0]  rd_ptr,
    input logic [7:0]  bcount,
    input logic [2:0]  freq_code,
    input logic [15:0] cpu_freq
);

    AST_OE_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(fs_pin_oe) |-> $past(strap_vld_n)); // R1

    AST_OE_STICKY: assert property (@(posedge clk) disable iff (rst)
        fs_pin_oe |=> fs_pin_oe); // R1

    AST_B0_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ptr == 4'd0) |-> (rd_data[7:2] == 6'd0)); // R2

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ptr == 4'd7) |-> (rd_data == 8'h01)); // R4

    AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ptr > 4'd8) |-> (rd_data == 8'h00)); // R5

    AST_SINGLE_START: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_block && !rd_valid) |=> (rd_valid && rd_ptr == $past(rd_addr))); // R6

    AST_SINGLE_END: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_block && !rd_valid) |=> ##1 !rd_valid); // R6

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ptr >= 4'd8) |=> (!rd_valid || rd_ptr == 4'd0)); // R7

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_block && bcount == 8'd0 && !rd_valid) |=> !rd_valid); // R7

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ptr < 4'd8) |=> (!rd_valid || rd_ptr == $past(rd_ptr) + 4'd1)); // R8

    AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (freq_code == $past(freq_code)) |=> $stable(cpu_freq)); // R9

endmodule

bind cfg_bank cfg_bank_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .strap_vld_n (strap_vld_n),
    .fs_pin_oe   (fs_pin_oe),
    .rd_req      (rd_req),
    .rd_block    (rd_block),
    .rd_addr     (rd_addr),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_ptr      (rd_ptr),
    .bcount      (bcount),
    .freq_code   (freq_code),
    .cpu_freq    (cpu_freq)
);

// File: tb/cfg_bank_tb.sv
module cfg_bank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_vld_n = 1'b1;
    logic        fs_a_pin = 1'b0;
    logic        fs_b_pin = 1'b0;
    logic        fs_pin_oe;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_req = 1'b0;
    logic        rd_block = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [47:0] ctrl_bytes;
    logic [15:0] cpu_freq;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    logic [7:0] shadow [16];
    logic [7:0] got [300];
    int         ngot;

    always #4 clk = ~clk;

    cfg_bank u_dut (
        .clk(clk), .rst(rst), .strap_vld_n(strap_vld_n),
        .fs_a_pin(fs_a_pin), .fs_b_pin(fs_b_pin), .fs_pin_oe(fs_pin_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_block(rd_block), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ctrl_bytes(ctrl_bytes), .cpu_freq(cpu_freq)
    );

    function automatic logic [7:0] b_mask(input int i);
        case (i)
            1: return 8'hC3; 2: return 8'hD8; 3: return 8'hBF; 4: return 8'hC7;
            5: return 8'hF7; 6: return 8'hDF; 8: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] b_rst(input int i);
        case (i)
            1: return 8'h43; 3: return 8'hBF; 4: return 8'hC7; 5: return 8'hD7;
            6: return 8'h03; 7: return 8'h01; 8: return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] exp_freq(input logic [2:0] c);
        case (c)
            3'd0: return 16'd10000; 3'd1: return 16'd20000;
            3'd2: return 16'd13333; 3'd3: return 16'd16666;
            3'd4: return 16'd20000; 3'd5: return 16'd40000;
            3'd6: return 16'd26666; default: return 16'd33333;
        endcase
    endfunction

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic a, input logic b);
        @(negedge clk);
        rst = 1'b1; strap_vld_n = 1'b1; fs_a_pin = a; fs_b_pin = b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) shadow[i] = b_rst(i);
    endtask

    task automatic capture(input logic a, input logic b);
        @(negedge clk);
        fs_a_pin = ~a; fs_b_pin = ~b; strap_vld_n = 1'b0;
        @(negedge clk);
        fs_a_pin = a; fs_b_pin = b;
        @(negedge clk);
        strap_vld_n = 1'b1;
        @(negedge clk);
        shadow[0] = {6'd0, b, a};
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        shadow[a] = (d & b_mask(a)) | (shadow[a] & ~b_mask(a));
    endtask

    task automatic rd(input logic [3:0] a, input logic blk);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a; rd_block = blk;
        @(negedge clk);
        rd_req = 1'b0;
        ngot = 0;
        while (rd_valid && ngot < 300) begin
            got[ngot] = rd_data;
            ngot++;
            @(negedge clk);
        end
    endtask

    function automatic logic [47:0] exp_ctrl();
        return {shadow[6], shadow[5], shadow[4], shadow[3], shadow[2], shadow[1]};
    endfunction

    task automatic t_reset_state();
        do_reset(1'b1, 1'b0);
        repeat (2) @(negedge clk);
        check("R1 oe low before strobe", fs_pin_oe, 0);
        check("R3 ctrl reset", ctrl_bytes, 48'h03D7C7BF0043);
        check("R10 spread fields reset", ctrl_bytes[44:42], 0);
        check("R9 freq after reset", cpu_freq, 16'd10000);
        rd(4'd0, 1'b0);
        check("R1 straps zero before capture", got[0], 8'h00);
        rd(4'd8, 1'b0);
        check("R3 byte count reset", got[0], 8'h08);
    endtask

    task automatic t_capture();
        capture(1'b1, 1'b0);
        check("R1 oe after release", fs_pin_oe, 1);
        rd(4'd0, 1'b0);
        check("R2 byte0 captured", got[0], 8'h01);
        @(negedge clk);
        strap_vld_n = 1'b0; fs_a_pin = 1'b0; fs_b_pin = 1'b1;
        repeat (2) @(negedge clk);
        strap_vld_n = 1'b1;
        @(negedge clk);
        rd(4'd0, 1'b0);
        check("R1 later strobe ignored", got[0], 8'h01);
        check("R1 oe sticky", fs_pin_oe, 1);
        wr(4'd0, 8'hFF);
        rd(4'd0, 1'b0);
        check("R2 byte0 write ignored", got[0], 8'h01);
    endtask

    task automatic t_masks();
        for (int i = 1; i < 16; i++) begin
            wr(4'(i), 8'hFF);
            rd(4'(i), 1'b0);
            check($sformatf("R5 all-ones byte %0d", i), got[0], shadow[i]);
            check($sformatf("R6 single len byte %0d", i), ngot, 1);
        end
        check("R3 ctrl after ones", ctrl_bytes, exp_ctrl());
        rd(4'd7, 1'b0);
        check("R4 id fixed", got[0], 8'h01);
        for (int i = 1; i < 9; i++) wr(4'(i), 8'h00);
        wr(4'd8, 8'h08);
        check("R3 ctrl after zeros", ctrl_bytes, exp_ctrl());
        wr(4'd6, 8'h1C);
        check("R10 src/center/spread bits", ctrl_bytes[44:42], 3'b111);
        wr(4'd6, 8'h08);
        check("R10 center only", ctrl_bytes[44:42], 3'b010);
        rd(4'd6, 1'b0);
        check("R10 byte6 readback", got[0], 8'h08);
    endtask

    task automatic t_block(input logic [3:0] a, input logic [7:0] cnt);
        int p;
        wr(4'd8, cnt);
        rd(a, 1'b1);
        check($sformatf("R7 length cnt=%0d", cnt), ngot, cnt);
        p = a;
        for (int k = 0; k < ngot && k < cnt; k++) begin
            check($sformatf("R7 byte %0d from addr %0d", k, a), got[k],
                  (p < 9) ? shadow[p] : 8'h00);
            p = (p >= 8) ? 0 : p + 1;
        end
    endtask

    task automatic t_busy();
        wr(4'd8, 8'd6);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = 4'd2; rd_block = 1'b1;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = 4'd7; rd_block = 1'b0;
        ngot = 0;
        while (rd_valid && ngot < 300) begin
            got[ngot] = rd_data;
            ngot++;
            @(negedge clk);
            rd_req = 1'b0;
        end
        rd_req = 1'b0;
        check("R8 length unchanged", ngot, 6);
        check("R8 second byte", got[1], shadow[3]);
        check("R8 last byte", got[5], shadow[7]);
    endtask

    task automatic t_freq(input logic a, input logic b);
        do_reset(a, b);
        capture(a, b);
        check($sformatf("R9 freq code %0d", {1'b0, b, a}), cpu_freq, exp_freq({1'b0, b, a}));
        wr(4'd6, 8'h43);
        check("R9 freq one cycle latency", cpu_freq, exp_freq({1'b0, b, a}));
        @(negedge clk);
        check($sformatf("R9 freq code %0d", {1'b1, b, a}), cpu_freq, exp_freq({1'b1, b, a}));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_capture();
        t_masks();
        t_block(4'd0, 8'd8);
        t_block(4'd7, 8'd3);
        t_block(4'd0, 8'd12);
        t_block(4'd12, 8'd3);
        t_block(4'd3, 8'd0);
        t_busy();
        t_freq(1'b0, 1'b0);
        t_freq(1'b1, 1'b0);
        t_freq(1'b0, 1'b1);
        t_freq(1'b1, 1'b1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule